// File: doc/BRIEF.md
# HDLC Controller Status Byte

This block assembles the one-byte status word of a single-channel HDLC controller that owns a 64-byte receive FIFO and a 64-byte transmit FIFO. Three of its bits are sticky event flags: they are set by single-cycle strobes from the HDLC receiver and transmitter and stay set until software reads the byte. Four bits are live level flags computed every cycle from the FIFO occupancy counts. The remaining bit reports loss of carrier. A counter of consecutive all-zero bit periods on the two line rails drives it.

Software reads the byte through a plain read port. `stat_byte` always shows the current contents. A read is marked by pulsing `rd_stb` for one cycle. The sticky bits that were seen during that read clear on the following clock edge. An event that arrives in the same cycle as the read is not lost. Every clock cycle counts as one line bit period for the carrier monitor. `long_run_sel` picks the run length that signals carrier loss.

The bit order, from bit 7 down to bit 0, is: transmit-done, receive-half-full, transmit-half-empty, carrier-loss, receive-not-empty, receive-packet-end, receive-packet-start, transmit-not-full.

Top module: `hdlc_stat_reg`

## Requirements
- R1: A pulse on `ev_tx_done` sets bit 7 of `stat_byte` from the next cycle on. The bit stays set for as long as no read occurs.
- R2: Bit 2 sets in the cycle after any one of four strobes is high: `ev_rx_good_end`, `ev_rx_crc_err`, `ev_rx_overrun` or `ev_rx_abort`.
- R3: A pulse on `ev_rx_open_flag` sets bit 1 from the next cycle on.
- R4: During the cycle in which `rd_stb` is high, `stat_byte` still shows the sticky bits as they were. In the next cycle, bits 7, 2 and 1 read 0 unless a new event was strobed.
- R5: A strobe that arrives in the same cycle as `rd_stb` leaves its sticky bit set after the read.
- R6: Bit 6 is 1 exactly when `rx_fill` is greater than 32. It reads 0 at 32 and 1 at 33.
- R7: Bit 3 is 1 exactly when `rx_fill` is 1 or more.
- R8: Bit 5 is 1 exactly when `tx_fill` is less than 32. It reads 1 at 31 and 0 at 32.
- R9: Bit 0 is 1 exactly when `tx_fill` is less than 64.
- R10: With `long_run_sel` = 0, bit 4 sets once both `line_pos` and `line_neg` have been 0 at 255 consecutive clock edges. It is still 0 after 254 such edges.
- R11: With `long_run_sel` = 1, bit 4 sets after 2048 consecutive all-zero edges. It is still 0 after 2047.
- R12: The zero counter saturates, so bit 4 stays set while the zeros continue. A 1 on either rail at a clock edge clears the counter, and bit 4 reads 0 in the next cycle.
- R13: A synchronous active-high `rst` clears the three sticky bits and the zero counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle equals one line bit period |
| rst | input | 1 | Synchronous active-high reset |
| rx_fill | input | 7 | Receive FIFO occupancy in bytes (0..64) |
| tx_fill | input | 7 | Transmit FIFO occupancy in bytes (0..64) |
| ev_rx_good_end | input | 1 | Strobe: frame ended with a good CRC |
| ev_rx_crc_err | input | 1 | Strobe: frame ended with a CRC error |
| ev_rx_overrun | input | 1 | Strobe: receive overrun |
| ev_rx_abort | input | 1 | Strobe: abort sequence detected |
| ev_rx_open_flag | input | 1 | Strobe: opening flag byte detected |
| ev_tx_done | input | 1 | Strobe: transmitter finished a message |
| line_pos | input | 1 | Positive line rail data |
| line_neg | input | 1 | Negative line rail data |
| long_run_sel | input | 1 | 0: 255-zero run length, 1: 2048-zero run length |
| rd_stb | input | 1 | One-cycle read strobe for the status byte |
| stat_byte | output | 8 | Status byte as described above |

## Verification
Directed sequences cover each sticky bit on its own, each of the four causes of packet end, a read without events, and a read that coincides with an event. These separate the clear path from the set path. The FIFO counts are driven across 0/1, 31/32/33 and 63/64, which tells a strict comparison apart from an inclusive one. Zero runs of 254/255 and 2047/2048, followed by a single 1 on each rail in turn, show that the threshold is exact, that the counter saturates, and that both rails reset it. A long constrained-random phase mixes strobes, reads, fill levels and bursts of zeros, and compares every bit against a model built from the requirements.

// File: rtl/hdlc_stat_pkg.sv
package hdlc_stat_pkg;
  // Bit positions inside the status byte; software decodes these.
  localparam int unsigned B_TX_DONE   = 7;
  localparam int unsigned B_RX_HALF   = 6;
  localparam int unsigned B_TX_HALFE  = 5;
  localparam int unsigned B_CARRIER   = 4;
  localparam int unsigned B_RX_NE     = 3;
  localparam int unsigned B_RX_END    = 2;
  localparam int unsigned B_RX_START  = 1;
  localparam int unsigned B_TX_NF     = 0;

  // Index of each sticky flag inside the event latch bank.
  localparam int unsigned EV_TX_DONE  = 0;
  localparam int unsigned EV_RX_END   = 1;
  localparam int unsigned EV_RX_START = 2;
  localparam int unsigned EV_COUNT    = 3;

  typedef struct packed {
    logic rx_half;
    logic rx_ne;
    logic tx_half_empty;
    logic tx_not_full;
  } fifo_lvl_t;
endpackage

// File: rtl/hdlc_event_latch.sv
module hdlc_event_latch #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] ev,
  output logic [N-1:0] q
);
  // A new event wins over a read clear in the same cycle.
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        q[i] <= 1'b0;
      else if (ev[i])
        q[i] <= 1'b1;
      else if (clr)
        q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/hdlc_fifo_level.sv
module hdlc_fifo_level
  import hdlc_stat_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] rx_fill,
  input  logic [CW-1:0] tx_fill,
  output fifo_lvl_t     lvl
);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  always_comb begin
    lvl.rx_half       = (rx_fill > HALF);
    lvl.rx_ne         = (rx_fill != '0);
    lvl.tx_half_empty = (tx_fill < HALF);
    lvl.tx_not_full   = (tx_fill < FULL);
  end
endmodule

// File: rtl/hdlc_carrier_mon.sv
module hdlc_carrier_mon #(
  parameter int unsigned SHORT_RUN = 255,
  parameter int unsigned LONG_RUN  = 2048,
  parameter int unsigned RW        = $clog2(LONG_RUN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic line_pos,
  input  logic line_neg,
  input  logic long_sel,
  output logic loss
);
  localparam logic [RW-1:0] THR_S = RW'(SHORT_RUN);
  localparam logic [RW-1:0] THR_L = RW'(LONG_RUN);

  logic [RW-1:0] zcnt;
  logic [RW-1:0] thr;
  logic          mark;

  assign thr  = long_sel ? THR_L : THR_S;
  assign mark = line_pos | line_neg;
  assign loss = (zcnt >= thr);

  always_ff @(posedge clk) begin
    if (rst || mark)
      zcnt <= '0;
    else if (zcnt < thr)
      zcnt <= zcnt + 1'b1;
  end
endmodule

// File: rtl/hdlc_stat_reg.sv
module hdlc_stat_reg
  import hdlc_stat_pkg::*;
#(
  parameter  int unsigned FIFO_DEPTH = 64,
  parameter  int unsigned SHORT_RUN  = 255,
  parameter  int unsigned LONG_RUN   = 2048,
  localparam int unsigned FILL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] tx_fill,
  input  logic              ev_rx_good_end,
  input  logic              ev_rx_crc_err,
  input  logic              ev_rx_overrun,
  input  logic              ev_rx_abort,
  input  logic              ev_rx_open_flag,
  input  logic              ev_tx_done,
  input  logic              line_pos,
  input  logic              line_neg,
  input  logic              long_run_sel,
  input  logic              rd_stb,
  output logic [7:0]        stat_byte
);
  logic [EV_COUNT-1:0] ev_vec;
  logic [EV_COUNT-1:0] sticky;
  fifo_lvl_t           lvl;
  logic                loss;

  always_comb begin
    ev_vec              = '0;
    ev_vec[EV_TX_DONE]  = ev_tx_done;
    ev_vec[EV_RX_END]   = ev_rx_good_end | ev_rx_crc_err | ev_rx_overrun | ev_rx_abort;
    ev_vec[EV_RX_START] = ev_rx_open_flag;
  end

  hdlc_event_latch #(.N(EV_COUNT)) u_events (
    .clk (clk),
    .rst (rst),
    .clr (rd_stb),
    .ev  (ev_vec),
    .q   (sticky)
  );

  hdlc_fifo_level #(.DEPTH(FIFO_DEPTH), .CW(FILL_W)) u_levels (
    .rx_fill (rx_fill),
    .tx_fill (tx_fill),
    .lvl     (lvl)
  );

  hdlc_carrier_mon #(.SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)) u_carrier (
    .clk      (clk),
    .rst      (rst),
    .line_pos (line_pos),
    .line_neg (line_neg),
    .long_sel (long_run_sel),
    .loss     (loss)
  );

  always_comb begin
    stat_byte             = '0;
    stat_byte[B_TX_DONE]  = sticky[EV_TX_DONE];
    stat_byte[B_RX_HALF]  = lvl.rx_half;
    stat_byte[B_TX_HALFE] = lvl.tx_half_empty;
    stat_byte[B_CARRIER]  = loss;
    stat_byte[B_RX_NE]    = lvl.rx_ne;
    stat_byte[B_RX_END]   = sticky[EV_RX_END];
    stat_byte[B_RX_START] = sticky[EV_RX_START];
    stat_byte[B_TX_NF]    = lvl.tx_not_full;
  end
endmodule

// File: rtl/hdlc_stat_chk.sv
module hdlc_stat_chk
  import hdlc_stat_pkg::*;
#(
  parameter int unsigned FILL_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [FILL_W-1:0] rx_fill,
  input logic [FILL_W-1:0] tx_fill,
  input logic              ev_rx_good_end,
  input logic              ev_rx_crc_err,
  input logic              ev_rx_overrun,
  input logic              ev_rx_abort,
  input logic              ev_rx_open_flag,
  input logic              ev_tx_done,
  input logic              line_pos,
  input logic              line_neg,
  input logic              long_run_sel,
  input logic              rd_stb,
  input logic [7:0]        stat_byte
);
  AST_TXDONE_SET: assert property (@(posedge clk) disable iff (rst)
    ev_tx_done |=> stat_byte[B_TX_DONE]); // R1
  AST_TXDONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stat_byte[B_TX_DONE] && !rd_stb) |=> stat_byte[B_TX_DONE]); // R1
  AST_RXEND_ANY: assert property (@(posedge clk) disable iff (rst)
    (ev_rx_good_end || ev_rx_crc_err || ev_rx_overrun || ev_rx_abort) |=> stat_byte[B_RX_END]); // R2
  AST_RXSTART_SET: assert property (@(posedge clk) disable iff (rst)
    ev_rx_open_flag |=> stat_byte[B_RX_START]); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !ev_tx_done && !ev_rx_open_flag) |=> (!stat_byte[B_TX_DONE] && !stat_byte[B_RX_START])); // R4
  AST_READ_KEEPS_EVENT: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && ev_tx_done) |=> stat_byte[B_TX_DONE]); // R5
  AST_LOSS_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_byte[B_CARRIER]) |-> $past(!line_pos && !line_neg)); // R10
  AST_LOSS_CLEARED_BY_MARK: assert property (@(posedge clk) disable iff (rst)
    (line_pos || line_neg) |=> !stat_byte[B_CARRIER]); // R12
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!stat_byte[B_TX_DONE] && !stat_byte[B_RX_END] && !stat_byte[B_RX_START] && !stat_byte[B_CARRIER])); // R13
endmodule

bind hdlc_stat_reg hdlc_stat_chk #(.FILL_W(FILL_W)) u_chk (.*);

// File: tb/hdlc_stat_reg_bench.sv
module hdlc_stat_reg_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] rx_fill = '0;
  logic [6:0] tx_fill = '0;
  logic ev_rx_good_end = 0, ev_rx_crc_err = 0, ev_rx_overrun = 0, ev_rx_abort = 0;
  logic ev_rx_open_flag = 0, ev_tx_done = 0;
  logic line_pos = 1, line_neg = 0, long_run_sel = 0, rd_stb = 0;
  logic [7:0] stat_byte;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // Requirement-level model
  bit m_txd, m_rxe, m_rxs;
  int m_zc;

  always #10 clk = ~clk;

  hdlc_stat_reg u_hdlc_stat_reg (.*);

  function automatic logic [7:0] expect_byte();
    int thr = long_run_sel ? 2048 : 255;
    return {m_txd, rx_fill > 32, tx_fill < 32, m_zc >= thr,
            rx_fill != 0, m_rxe, m_rxs, tx_fill < 64};
  endfunction

  function automatic string req_of(int b);
    case (b)
      7: return "R1"; 6: return "R6"; 5: return "R8"; 4: return "R10";
      3: return "R7"; 2: return "R2"; 1: return "R3"; default: return "R9";
    endcase
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Compare, then clock once with the current inputs and update the model.
  task automatic cycle();
    logic [7:0] e;
    int thr;
    #1;
    e = expect_byte();
    checks++;
    if (stat_byte !== e) begin
      errors++;
      for (int b = 7; b >= 0; b--)
        if (stat_byte[b] !== e[b])
          $display("FAIL %s bit%0d: actual=%0b expected=%0b", req_of(b), b, stat_byte[b], e[b]);
    end
    @(posedge clk);
    thr = long_run_sel ? 2048 : 255;
    if (rst) begin
      m_txd = 0; m_rxe = 0; m_rxs = 0; m_zc = 0;
    end else begin
      m_txd = (m_txd && !rd_stb) || ev_tx_done;
      m_rxe = (m_rxe && !rd_stb) || ev_rx_good_end || ev_rx_crc_err || ev_rx_overrun || ev_rx_abort;
      m_rxs = (m_rxs && !rd_stb) || ev_rx_open_flag;
      if (line_pos || line_neg) m_zc = 0;
      else if (m_zc < thr) m_zc++;
    end
    cycles++;
    @(negedge clk);
  endtask

  task automatic quiet();
    {ev_rx_good_end, ev_rx_crc_err, ev_rx_overrun, ev_rx_abort, ev_rx_open_flag, ev_tx_done, rd_stb} = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    repeat (3) cycle();
    rst = 0;
    #1;
    chk("R13 tx_done after reset", stat_byte[7], 1'b0);
    chk("R13 rx_end after reset", stat_byte[2], 1'b0);
    chk("R13 carrier after reset", stat_byte[4], 1'b0);

    // R1 set and hold
    ev_tx_done = 1; cycle(); quiet();
    #1 chk("R1 tx_done set", stat_byte[7], 1'b1);
    repeat (3) cycle();
    chk("R1 tx_done held", stat_byte[7], 1'b1);
    // R4 read shows old value, then clears
    rd_stb = 1; #1 chk("R4 value visible during read", stat_byte[7], 1'b1);
    cycle(); quiet();
    #1 chk("R4 cleared after read", stat_byte[7], 1'b0);
    // R2 each cause
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: ev_rx_good_end = 1;
        1: ev_rx_crc_err = 1;
        2: ev_rx_overrun = 1;
        default: ev_rx_abort = 1;
      endcase
      cycle(); quiet();
      #1 chk("R2 packet end cause", stat_byte[2], 1'b1);
      rd_stb = 1; cycle(); quiet();
      #1 chk("R4 packet end cleared", stat_byte[2], 1'b0);
    end
    // R3
    ev_rx_open_flag = 1; cycle(); quiet();
    #1 chk("R3 open flag set", stat_byte[1], 1'b1);
    // R5 event with read
    rd_stb = 1; ev_tx_done = 1; ev_rx_open_flag = 1; cycle(); quiet();
    #1 chk("R5 tx_done kept", stat_byte[7], 1'b1);
    chk("R5 open flag kept", stat_byte[1], 1'b1);
    rd_stb = 1; cycle(); quiet();

    // R6..R9 boundaries
    rx_fill = 32; #1 chk("R6 rx 32", stat_byte[6], 1'b0);
    rx_fill = 33; #1 chk("R6 rx 33", stat_byte[6], 1'b1);
    rx_fill = 0;  #1 chk("R7 rx 0", stat_byte[3], 1'b0);
    rx_fill = 1;  #1 chk("R7 rx 1", stat_byte[3], 1'b1);
    tx_fill = 31; #1 chk("R8 tx 31", stat_byte[5], 1'b1);
    tx_fill = 32; #1 chk("R8 tx 32", stat_byte[5], 1'b0);
    tx_fill = 63; #1 chk("R9 tx 63", stat_byte[0], 1'b1);
    tx_fill = 64; #1 chk("R9 tx 64", stat_byte[0], 1'b0);
    cycle();

    // R10 short run
    line_pos = 1; cycle();
    line_pos = 0; line_neg = 0; long_run_sel = 0;
    repeat (254) cycle();
    #1 chk("R10 after 254 zeros", stat_byte[4], 1'b0);
    cycle();
    #1 chk("R10 after 255 zeros", stat_byte[4], 1'b1);
    repeat (20) cycle();
    #1 chk("R12 saturated stays set", stat_byte[4], 1'b1);
    line_neg = 1; cycle(); line_neg = 0;
    #1 chk("R12 neg rail clears", stat_byte[4], 1'b0);
    repeat (255) cycle();
    #1 chk("R10 rerun to 255", stat_byte[4], 1'b1);
    line_pos = 1; cycle(); line_pos = 0;
    #1 chk("R12 pos rail clears", stat_byte[4], 1'b0);
    // R11 long run
    long_run_sel = 1;
    repeat (2047) cycle();
    #1 chk("R11 after 2047 zeros", stat_byte[4], 1'b0);
    cycle();
    #1 chk("R11 after 2048 zeros", stat_byte[4], 1'b1);
    // R13 reset clears counter and sticky
    ev_tx_done = 1; cycle(); quiet();
    rst = 1; cycle(); rst = 0;
    #1 chk("R13 reset clears carrier", stat_byte[4], 1'b0);
    chk("R13 reset clears tx_done", stat_byte[7], 1'b0);

    // Constrained random phase
    for (int n = 0; n < 4000; n++) begin
      int burst;
      burst = (n % 500) < 300;
      ev_tx_done      = ($urandom % 8) == 0;
      ev_rx_good_end  = ($urandom % 16) == 0;
      ev_rx_crc_err   = ($urandom % 32) == 0;
      ev_rx_overrun   = ($urandom % 32) == 0;
      ev_rx_abort     = ($urandom % 32) == 0;
      ev_rx_open_flag = ($urandom % 10) == 0;
      rd_stb          = ($urandom % 6) == 0;
      rx_fill         = 7'($urandom % 65);
      tx_fill         = 7'($urandom % 65);
      long_run_sel    = (n >= 2000);
      line_pos        = burst ? 1'b0 : (($urandom % 4) == 0);
      line_neg        = burst ? 1'b0 : (($urandom % 4) == 0);
      cycle();
    end
    quiet();
    cycle();
    summary();
  end
endmodule